// File: doc/BRIEF.md
# Supply Guard Interrupt Controller

This block is the digital control and status logic of a brown-out monitor that watches two supplies, one analog and one digital. It holds an 8-bit control/status register on a simple CPU register bus and drives a 3-bit threshold code to two external comparators. It takes the comparators' "supply good" results as synchronous inputs and filters them against glitches. When the monitor is enabled and either filtered result is low, it raises a sticky fault flag. It also records which supply caused the fault.

The fault flag drives an interrupt request through an external enable gate. Software may set the flag, but it cannot clear it while a supply is low. The flag clears itself only after both supplies have stayed good for an unbroken hold-off of `HOLD_CYCLES` clock cycles. This lets an interrupt handler poll the flag and resume only once power has settled.

Top module: `supply_guard`

## Requirements
- R1: After reset the register reads 0xDC, `tripCode` is 3'b111 and `irqOut` is 0.
- R2: Register bit layout. Bit 7 always reads 1 and ignores writes. Bit 6 is read-only. Bits 4:2 hold the threshold code, which is read back and driven on `tripCode` (000=4.63 V, 001=4.37 V, 010=3.08 V, 011=2.93 V, 100=2.63 V). Bit 0 is the monitor enable.
- R3: Bit 6 reads 1 only when both filtered comparator results are good, and 0 when either one is low.
- R4: A comparator change reaches bit 6 only after the raw input has held the new level for `FILT_LEN` consecutive cycles. The change shows exactly `FILT_LEN`+2 clock edges after the input changes. A pulse of `FILT_LEN`-1 cycles has no effect.
- R5: With bit 0 set, a low bit 6 sets the fault flag (bit 5) at the next edge. With bit 0 clear, no fault is latched.
- R6: Bit 1 is captured when a fault sets the flag from 0. It is 1 if the analog supply is low (the analog supply wins if both are low) and 0 if only the digital supply is low. It does not change while the flag stays set.
- R7: The flag clears by itself exactly `HOLD_CYCLES` edges after bit 6 becomes 1, provided bit 6 stays 1 throughout. Any low bit 6 restarts the count. While bit 0 is clear the count is held at zero.
- R8: Writing 1 to bit 5 sets the flag. Writing 0 clears it only when bit 6 is 1; while bit 6 is 0 such a write has no effect.
- R9: `irqOut` equals the flag ANDed with `irqEnable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| aOkIn | input | 1 | Analog supply comparator, 1 = above threshold |
| dOkIn | input | 1 | Digital supply comparator, 1 = above threshold |
| irqEnable | input | 1 | External interrupt enable |
| tripCode | output | 3 | Threshold code to the comparators |
| irqOut | output | 1 | Interrupt request |

## Verification
The supply inputs are driven in four patterns. A pulse one cycle shorter than the filter length shows that glitches are rejected. A held drop is sampled on the exact edge where bit 6 falls and again where the flag rises, which pins down the filter latency. Separate analog-only, digital-only and overlapping drops tell the source capture apart. A recovery broken by a second drop shows that the hold-off restarts, because the flag outlives the point where an unbroken count would have ended. Software clears are tried once while a supply is low and once while both are good, and a drop with the monitor disabled shows that nothing is latched.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  // Strobes from control to the register datapath
  typedef struct packed {
    logic setFlag;     // hardware fault present this cycle
    logic srcAnalog;   // analog supply is the low one
    logic autoClr;     // hold-off expired
    logic allowSwClr;  // software may clear the flag
  } sgdStrobe_t;

  localparam int BIT_FIXED = 7;
  localparam int BIT_CMP   = 6;
  localparam int BIT_FLAG  = 5;
  localparam int BIT_TRIPH = 4;
  localparam int BIT_TRIPL = 2;
  localparam int BIT_SRC   = 1;
  localparam int BIT_EN    = 0;
  localparam logic [2:0] TRIP_RESET = 3'b111;
endpackage

// File: rtl/sgd_deglitch.sv
module sgd_deglitch #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic syncA, syncB;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      cleanOut <= 1'b1;
      runCnt   <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (syncB == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CNT_LAST) begin
        cleanOut <= syncB;
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgd_ctrl.sv
module sgd_ctrl
  import sgd_pkg::*;
#(
  parameter int HOLD_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aOk,
  input  logic       dOk,
  input  logic       monEn,
  input  logic       flag,
  output sgdStrobe_t strobe
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  logic bothOk;
  logic [HOLD_W-1:0] holdCnt;

  assign bothOk = aOk & dOk;

  always_comb begin
    strobe.setFlag    = monEn & ~bothOk;
    strobe.srcAnalog  = ~aOk;
    strobe.autoClr    = monEn & bothOk & flag & (holdCnt == HOLD_LAST);
    strobe.allowSwClr = bothOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!monEn || !bothOk || !flag || strobe.autoClr) begin
      holdCnt <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sgd_regs.sv
module sgd_regs
  import sgd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [5:0] wrData,
  input  sgdStrobe_t strobe,
  input  logic       cmpBoth,
  output logic [7:0] rdData,
  output logic       monEn,
  output logic       flag,
  output logic [2:0] trip
);
  logic srcBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      monEn  <= 1'b0;
      trip   <= TRIP_RESET;
      flag   <= 1'b0;
      srcBit <= 1'b0;
    end else begin
      if (wrEn) begin
        monEn <= wrData[BIT_EN];
        trip  <= wrData[BIT_TRIPH:BIT_TRIPL];
      end
      if (strobe.setFlag) begin
        flag <= 1'b1;
        if (!flag) srcBit <= strobe.srcAnalog;
      end else if (strobe.autoClr) begin
        flag <= 1'b0;
      end else if (wrEn) begin
        if (wrData[BIT_FLAG]) flag <= 1'b1;
        else if (strobe.allowSwClr) flag <= 1'b0;
      end
    end
  end

  assign rdData = {1'b1, cmpBoth, flag, trip, srcBit, monEn};
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import sgd_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int HOLD_CYCLES = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       aOkIn,
  input  logic       dOkIn,
  input  logic       irqEnable,
  output logic [2:0] tripCode,
  output logic       irqOut
);
  localparam int N_SUP = 2;  // index 1 analog, index 0 digital

  logic [N_SUP-1:0] rawOk, cleanOk;
  logic monEn, flag;
  sgdStrobe_t strobe;
  logic unusedWrHi;

  assign rawOk      = {aOkIn, dOkIn};
  assign unusedWrHi = ^regWrData[7:6];

  for (genvar i = 0; i < N_SUP; i++) begin : gFilt
    sgd_deglitch #(.FILT_LEN(FILT_LEN)) uFilt (
      .clk(clk), .rstN(rstN), .rawIn(rawOk[i]), .cleanOut(cleanOk[i])
    );
  end

  sgd_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .aOk(cleanOk[1]), .dOk(cleanOk[0]),
    .monEn(monEn), .flag(flag), .strobe(strobe)
  );

  sgd_regs uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrData(regWrData[5:0]),
    .strobe(strobe), .cmpBoth(&cleanOk), .rdData(regRdData),
    .monEn(monEn), .flag(flag), .trip(tripCode)
  );

  assign irqOut = flag & irqEnable;
endmodule

// File: rtl/sgd_checker.sv
module sgd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       irqEnable,
  input logic       irqOut,
  input logic [7:0] rdData
);
  AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && !rdData[6]) |=> rdData[5]);  // R5

  AST_FLAG_HELD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[5] && !rdData[6]) |=> rdData[5]);  // R8

  AST_CLEAR_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[5]) |-> $past(rdData[6]));  // R7

  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdData[5]) |-> $stable(rdData[1]));  // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqEnable);  // R9
endmodule

bind supply_guard sgd_checker u_chk (
  .clk(clk), .rstN(rstN), .irqEnable(irqEnable), .irqOut(irqOut), .rdData(regRdData)
);

// File: tb/sim_supply_guard.sv
module sim_supply_guard;
  localparam int FILT = 4;
  localparam int HOLD = 50;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, aOkIn = 1'b1, dOkIn = 1'b1, irqEnable = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic [2:0] tripCode;
  logic irqOut;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supply_guard #(.FILT_LEN(FILT), .HOLD_CYCLES(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .aOkIn(aOkIn), .dOkIn(dOkIn), .irqEnable(irqEnable),
    .tripCode(tripCode), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 reset read", regRdData, 8'hDC);
    chk("R1 reset tripCode", tripCode, 3'b111);
    chk("R1 reset irqOut", irqOut, 1'b0);
  endtask

  task automatic tRegs();
    regWrite(8'h0D);
    chk("R2 enable+trip 011", regRdData, 8'hCD);
    chk("R2 tripCode 011", tripCode, 3'b011);
    regWrite(8'h00);
    chk("R2 bits7/6 ignore write", regRdData, 8'hC0);
    chk("R3 cmp good reads 1", regRdData[6], 1'b1);
    regWrite(8'h11);
    chk("R2 trip 100 enable", regRdData, 8'hD1);
    chk("R2 tripCode 100", tripCode, 3'b100);
  endtask

  task automatic tGlitch();
    logic seen = 1'b0;
    aOkIn = 1'b0; tick(FILT - 1); aOkIn = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (regRdData[6] !== 1'b1 || regRdData[5] !== 1'b0) seen = 1'b1;
      tick(1);
    end
    chk("R4 short glitch ignored", seen, 1'b0);
  endtask

  task automatic tAnalogFault();
    irqEnable = 1'b1;
    aOkIn = 1'b0;
    tick(FILT + 1);
    chk("R4 cmp not yet low", regRdData[6], 1'b1);
    tick(1);
    chk("R4 cmp low at latency", regRdData[6], 1'b0);
    chk("R5 flag not yet set", regRdData[5], 1'b0);
    tick(1);
    chk("R5 flag set", regRdData[5], 1'b1);
    chk("R6 analog source", regRdData[1], 1'b1);
    chk("R9 irq with enable", irqOut, 1'b1);
    regWrite(8'h11);
    chk("R8 sw clear blocked while low", regRdData[5], 1'b1);
    irqEnable = 1'b0; #1;
    chk("R9 irq gated off", irqOut, 1'b0);
    irqEnable = 1'b1;
    aOkIn = 1'b1;
    tick(FILT + 1 + HOLD);
    chk("R7 flag held before hold-off end", regRdData[5], 1'b1);
    tick(1);
    chk("R7 flag auto cleared", regRdData[5], 1'b0);
    chk("R9 irq drops", irqOut, 1'b0);
  endtask

  task automatic tDigitalFault();
    dOkIn = 1'b0;
    tick(FILT + 3);
    chk("R6 digital source", regRdData[1], 1'b0);
    aOkIn = 1'b0;
    tick(FILT + 4);
    chk("R3 both low cmp 0", regRdData[6], 1'b0);
    chk("R6 source frozen", regRdData[1], 1'b0);
    aOkIn = 1'b1; dOkIn = 1'b1;
    tick(FILT + 2 + 20);
    dOkIn = 1'b0; tick(8); dOkIn = 1'b1;
    tick(FILT + 1 + HOLD);
    chk("R7 interrupted hold-off restarts", regRdData[5], 1'b1);
    tick(1);
    chk("R7 clears after full restart", regRdData[5], 1'b0);
  endtask

  task automatic tSoftware();
    regWrite(8'h31);
    chk("R8 sw set", regRdData, 8'hF1);
    regWrite(8'h11);
    chk("R8 sw clear when good", regRdData, 8'hD1);
  endtask

  task automatic tDisabled();
    regWrite(8'h10);
    aOkIn = 1'b0;
    tick(FILT + 10);
    chk("R3 cmp low while disabled", regRdData[6], 1'b0);
    chk("R5 no latch when disabled", regRdData[5], 1'b0);
    aOkIn = 1'b1;
    tick(FILT + 3);
    regWrite(8'h30);
    tick(HOLD + 10);
    chk("R7 count held when disabled", regRdData[5], 1'b1);
    regWrite(8'h10);
    chk("R8 sw clear disabled good", regRdData[5], 1'b0);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tReset();
    tRegs();
    tGlitch();
    tAnalogFault();
    tDigitalFault();
    tSoftware();
    tDisabled();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule